// File: doc/BRIEF.md
# SPI NAND Page Program and Block Erase Sequencer

This block drives a single-line SPI NAND device as bus master to run one of three jobs: a page program, a block erase or a stand-alone write disable. A program sends three separately framed commands: a write enable, a cache load, and a program execute. The cache load carries a 2-byte column address followed by payload bytes taken from a valid/ready stream. The execute carries a 3-byte row address. An erase sends a write enable and then a block erase with a 3-byte row address.

After an execute or an erase, the block does not read the status register itself. It hands control to an external busy poller with a one-cycle request. It then waits for the poller to return the final status byte or to report a timeout. The job ends with a one-cycle done pulse carrying a 2-bit result. The result comes from the fail bit that belongs to the operation: bit 3 for a program, bit 2 for an erase.

The serial clock is idle low and the device samples on the rising edge. Every command is one chip-select frame, and chip select is released for a fixed gap between frames.

Top module: `nand_pe_seq`

## Requirements
- R1: While reset is applied and after it is released with no start, spi_cs_no is 1 and spi_sclk_o, busy_o, done_o, poll_start_o and data_ready_o are 0.
- R2: Each command is one frame with spi_cs_no low throughout. Bytes go out MSB first. spi_mosi_o is stable while spi_sclk_o is high. spi_sclk_o only toggles while chip select is low. Between two frames of one job, chip select stays high for at least GAP_CYC clock cycles.
- R3: A program (op_i = 0) sends three frames in this order: [0x06]; [load opcode, column[15:8], column[7:0], then len_i payload bytes]; [0x10, row[23:16], row[15:8], row[7:0]].
- R4: The load opcode is 0x02 when load_rst_i is 1 (the rest of the cache is cleared) and 0x84 when load_rst_i is 0 (the rest of the cache is kept).
- R5: Payload byte n of the load is the nth byte accepted on data_valid_i & data_ready_o. data_ready_o is high only inside a load frame once the header has been sent. A low data_valid_i stretches the frame and leaves the bytes unchanged.
- R6: An erase (op_i = 1) sends two frames: [0x06] and [0xD8, row[23:16], row[15:8], row[7:0]].
- R7: After the execute or erase frame, poll_start_o is high for exactly one cycle, with chip select high. The block then waits for poll_done_i or poll_timeout_i.
- R8: result_o is 0 (ok) or 1 (failed). A program fails when status bit 3 is set. An erase fails when status bit 2 is set. The other operation's fail bit is ignored.
- R9: poll_timeout_i gives result 2 whatever the status byte holds.
- R10: op_i = 2 or 3 sends the single frame [0x04], issues no poll request, and ends with result 0.
- R11: done_o is a single-cycle pulse in the first cycle busy_o is low. A start_i received while busy_o is high is ignored.
- R12: A program with len_i = 0 sends a load frame of only the opcode and the two column bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job; sampled while idle |
| op_i | input | 2 | 0 program, 1 erase, 2/3 write disable |
| load_rst_i | input | 1 | 1 selects the cache-clearing load opcode |
| col_i | input | 16 | Column address for the load |
| row_i | input | 24 | Row address for execute or erase |
| len_i | input | LEN_W | Payload byte count |
| data_i | input | 8 | Payload byte |
| data_valid_i | input | 1 | Payload byte valid |
| data_ready_o | output | 1 | Payload byte taken this cycle if valid |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| result_o | output | 2 | 0 ok, 1 failed, 2 poller timeout |
| poll_start_o | output | 1 | Request to the external busy poller |
| poll_done_i | input | 1 | Poller saw ready; status valid |
| poll_status_i | input | 8 | Final status byte |
| poll_timeout_i | input | 1 | Poller gave up |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data out |

## Verification
A state or frame-kind register holding a wrong value shows up in the next frame the bench captures. The frame can have the wrong opcode, the wrong byte count or the wrong order, or it can be a missing or extra frame. That is visible within one byte time of the faulty transition. A header or payload counter that is off by one misaligns every later byte of the frame and changes its length. The bench compares every frame byte for byte, so one frame is enough to catch it. A slip in the result logic appears on result_o at the done pulse. The vectors set each fail bit alone under both operations to separate the two bit choices.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;

  localparam logic [7:0] OPC_WREN      = 8'h06;
  localparam logic [7:0] OPC_WRDIS     = 8'h04;
  localparam logic [7:0] OPC_LOAD_RST  = 8'h02;
  localparam logic [7:0] OPC_LOAD_KEEP = 8'h84;
  localparam logic [7:0] OPC_EXEC      = 8'h10;
  localparam logic [7:0] OPC_ERASE     = 8'hD8;

  localparam int PROG_FAIL_BIT  = 3;
  localparam int ERASE_FAIL_BIT = 2;

  typedef enum logic [2:0] {
    FR_WREN, FR_LOAD, FR_EXEC, FR_ERASE, FR_WRDIS
  } frame_e;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_FAIL    = 2'd1;
  localparam logic [1:0] RES_TIMEOUT = 2'd2;

  function automatic logic [31:0] hdr_of(frame_e k, logic lrst,
                                         logic [15:0] col, logic [23:0] row);
    case (k)
      FR_WREN:  return {OPC_WREN, 24'h0};
      FR_WRDIS: return {OPC_WRDIS, 24'h0};
      FR_LOAD:  return {(lrst ? OPC_LOAD_RST : OPC_LOAD_KEEP), col, 8'h0};
      FR_EXEC:  return {OPC_EXEC, row};
      FR_ERASE: return {OPC_ERASE, row};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] hdr_len(frame_e k);
    case (k)
      FR_LOAD:           return 3'd3;
      FR_EXEC, FR_ERASE: return 3'd4;
      default:           return 3'd1;
    endcase
  endfunction

  function automatic frame_e next_kind(frame_e k, logic is_prog);
    case (k)
      FR_WREN: return is_prog ? FR_LOAD : FR_ERASE;
      FR_LOAD: return FR_EXEC;
      default: return k;
    endcase
  endfunction

endpackage

// File: rtl/nand_spi_tx.sv
module nand_spi_tx #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  output logic       ready_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic             busy_q, phase_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [DIV_W-1:0] div_q;
  logic             half_end;

  assign half_end = (div_q == DIV_W'(SCLK_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      div_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        bit_q   <= 3'd7;
        sh_q    <= byte_i;
        div_q   <= '0;
      end
    end else if (!half_end) begin
      div_q <= div_q + 1'b1;
    end else begin
      div_q <= '0;
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (bit_q == 3'd0) busy_q <= 1'b0;
        else begin
          bit_q <= bit_q - 1'b1;
          sh_q  <= {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  assign ready_o = !busy_q;
  assign sclk_o  = busy_q & phase_q;
  assign mosi_o  = sh_q[7];
endmodule

// File: rtl/nand_pe_ctrl.sv
module nand_pe_ctrl
  import nand_pe_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int GAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             load_rst_i,
  input  logic [15:0]      col_i,
  input  logic [23:0]      row_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       data_i,
  input  logic             data_valid_i,
  output logic             data_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             poll_start_o,
  input  logic             poll_done_i,
  input  logic [7:0]       poll_status_i,
  input  logic             poll_timeout_i,
  output logic             tx_start_o,
  output logic [7:0]       tx_byte_o,
  input  logic             tx_ready_i,
  output logic             cs_n_o
);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP, ST_POLL} st_e;

  st_e              state_q;
  frame_e           frame_q, enter_kind;
  logic             is_prog_q, lrst_q;
  logic [15:0]      col_q;
  logic [23:0]      row_q;
  logic [LEN_W-1:0] len_q, dcnt_q;
  logic [31:0]      hdr_q;
  logic [2:0]       hcnt_q;
  logic [GAP_W-1:0] gap_q;
  logic             cs_n_q, done_q, poll_q;
  logic [1:0]       res_q;

  logic in_frame, hdr_pend, dat_pend, frame_end, enter_frame, fail_bit;

  assign in_frame  = (state_q == ST_FRAME);
  assign hdr_pend  = (hcnt_q != 3'd0);
  assign dat_pend  = (dcnt_q != '0);
  assign frame_end = in_frame & tx_ready_i & !hdr_pend & !dat_pend;

  assign tx_start_o   = in_frame & tx_ready_i & (hdr_pend | (dat_pend & data_valid_i));
  assign tx_byte_o    = hdr_pend ? hdr_q[31:24] : data_i;
  assign data_ready_o = in_frame & tx_ready_i & !hdr_pend & dat_pend;

  // first frame of a job never needs latched addresses
  assign enter_kind  = (state_q == ST_IDLE) ? (op_i[1] ? FR_WRDIS : FR_WREN) : frame_q;
  assign enter_frame = ((state_q == ST_IDLE) & start_i) |
                       ((state_q == ST_GAP) & (gap_q == '0));

  assign fail_bit = is_prog_q ? poll_status_i[PROG_FAIL_BIT] : poll_status_i[ERASE_FAIL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      frame_q   <= FR_WREN;
      is_prog_q <= 1'b0;
      lrst_q    <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      len_q     <= '0;
      dcnt_q    <= '0;
      hdr_q     <= '0;
      hcnt_q    <= '0;
      gap_q     <= '0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      res_q     <= RES_OK;
      poll_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      poll_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          is_prog_q <= (op_i == 2'd0);
          lrst_q    <= load_rst_i;
          col_q     <= col_i;
          row_q     <= row_i;
          len_q     <= len_i;
        end
        ST_FRAME: begin
          if (tx_start_o) begin
            if (hdr_pend) begin
              hdr_q  <= {hdr_q[23:0], 8'h0};
              hcnt_q <= hcnt_q - 1'b1;
            end else begin
              dcnt_q <= dcnt_q - 1'b1;
            end
          end else if (frame_end) begin
            cs_n_q <= 1'b1;
            case (frame_q)
              FR_WREN, FR_LOAD: begin
                state_q <= ST_GAP;
                gap_q   <= GAP_W'(GAP_CYC - 1);
                frame_q <= next_kind(frame_q, is_prog_q);
              end
              FR_EXEC, FR_ERASE: begin
                state_q <= ST_POLL;
                poll_q  <= 1'b1;
              end
              default: begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                res_q   <= RES_OK;
              end
            endcase
          end
        end
        ST_GAP: if (gap_q != '0) gap_q <= gap_q - 1'b1;
        ST_POLL: begin
          if (poll_timeout_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= RES_TIMEOUT;
          end else if (poll_done_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= fail_bit ? RES_FAIL : RES_OK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (enter_frame) begin
        state_q <= ST_FRAME;
        frame_q <= enter_kind;
        hdr_q   <= hdr_of(enter_kind, lrst_q, col_q, row_q);
        hcnt_q  <= hdr_len(enter_kind);
        dcnt_q  <= (enter_kind == FR_LOAD) ? len_q : '0;
        cs_n_q  <= 1'b0;
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign poll_start_o = poll_q;
  assign cs_n_o       = cs_n_q;
endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq #(
  parameter int LEN_W     = 12,
  parameter int GAP_CYC   = 2,
  parameter int SCLK_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             load_rst_i,
  input  logic [15:0]      col_i,
  input  logic [23:0]      row_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       data_i,
  input  logic             data_valid_i,
  output logic             data_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             poll_start_o,
  input  logic             poll_done_i,
  input  logic [7:0]       poll_status_i,
  input  logic             poll_timeout_i,
  output logic             spi_sclk_o,
  output logic             spi_cs_no,
  output logic             spi_mosi_o
);
  logic       tx_start, tx_ready;
  logic [7:0] tx_byte;

  nand_pe_ctrl #(.LEN_W(LEN_W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i, .load_rst_i, .col_i, .row_i, .len_i,
    .data_i, .data_valid_i, .data_ready_o, .busy_o, .done_o, .result_o,
    .poll_start_o, .poll_done_i, .poll_status_i, .poll_timeout_i,
    .tx_start_o(tx_start), .tx_byte_o(tx_byte), .tx_ready_i(tx_ready),
    .cs_n_o(spi_cs_no)
  );

  nand_spi_tx #(.SCLK_HALF(SCLK_HALF)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .byte_i(tx_byte),
    .ready_o(tx_ready), .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o)
  );
endmodule

// File: rtl/nand_pe_seq_chk.sv
module nand_pe_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       data_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o,
  input logic       poll_start_o,
  input logic       spi_sclk_o,
  input logic       spi_cs_no,
  input logic       spi_mosi_o
);
  p_cs_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> spi_cs_no);
  p_sclk_framed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !spi_cs_no);
  p_mosi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));
  p_ready_framed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> !spi_cs_no);
  p_poll_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_start_o |=> !poll_start_o);
  p_poll_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_start_o |-> spi_cs_no);
  p_result_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != 2'd3));
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_on_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind nand_pe_seq nand_pe_seq_chk u_chk (
  .clk_i, .rst_ni, .data_ready_o, .busy_o, .done_o, .result_o,
  .poll_start_o, .spi_sclk_o, .spi_cs_no, .spi_mosi_o
);

// File: tb/nand_pe_seq_bench.sv
module nand_pe_seq_bench;
  localparam int LEN_W = 12;
  localparam int GAP   = 2;
  localparam int NV    = 9;
  // {op[62:61], lrst[60], len[59:52], row[51:28], col[27:12], stat[11:4], tmo[3], res[2:1], stall[0]}
  localparam logic [62:0] VECS [0:NV-1] = '{
    {2'd0, 1'b1, 8'd4, 24'h012345, 16'h0010, 8'h00, 1'b0, 2'd0, 1'b0}, // R3 R4
    {2'd0, 1'b0, 8'd5, 24'h0000FF, 16'h0804, 8'h08, 1'b0, 2'd1, 1'b1}, // R4 R5 R8
    {2'd0, 1'b1, 8'd3, 24'hABCDEF, 16'h1234, 8'h04, 1'b0, 2'd0, 1'b0}, // R8
    {2'd1, 1'b0, 8'd0, 24'h000340, 16'h0000, 8'h00, 1'b0, 2'd0, 1'b0}, // R6
    {2'd1, 1'b0, 8'd0, 24'hFEDCBA, 16'h0000, 8'h04, 1'b0, 2'd1, 1'b0}, // R6 R8
    {2'd1, 1'b1, 8'd0, 24'h5A5A5A, 16'h0000, 8'h08, 1'b0, 2'd0, 1'b0}, // R8
    {2'd0, 1'b1, 8'd0, 24'h000001, 16'h0000, 8'h00, 1'b0, 2'd0, 1'b0}, // R12
    {2'd0, 1'b0, 8'd2, 24'h112233, 16'h0044, 8'h08, 1'b1, 2'd2, 1'b1}, // R9
    {2'd2, 1'b0, 8'd0, 24'h000000, 16'h0000, 8'h00, 1'b0, 2'd0, 1'b0}  // R10
  };

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, load_rst_i = 0, data_valid_i = 0;
  logic [1:0] op_i = 0;
  logic [15:0] col_i = 0;
  logic [23:0] row_i = 0;
  logic [LEN_W-1:0] len_i = 0;
  logic [7:0] data_i = 0, poll_status_i = 0;
  logic poll_done_i = 0, poll_timeout_i = 0;
  logic data_ready_o, busy_o, done_o, poll_start_o, spi_sclk_o, spi_cs_no, spi_mosi_o;
  logic [1:0] result_o;

  always #5 clk_i = ~clk_i;

  nand_pe_seq #(.LEN_W(LEN_W), .GAP_CYC(GAP)) u_nand_pe_seq (.*);

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // frame capture
  logic [7:0] cap_b [0:511];
  int f_start [0:15];
  int f_len [0:15];
  int nframes = 0, nbytes = 0, bitcnt = 0, misalign = 0, sclk_out = 0;
  int min_gap = 1000, ready_bad = 0, done_cnt = 0, poll_cnt = 0;
  bit in_frame = 0;
  logic [7:0] shreg = 0;
  time t_rise = 0;

  always @(posedge spi_sclk_o) begin
    shreg = {shreg[6:0], spi_mosi_o};
    bitcnt++;
    if (bitcnt == 8) begin
      if (nbytes < 512) cap_b[nbytes] = shreg;
      nbytes++;
      bitcnt = 0;
    end
  end
  always @(negedge spi_cs_no) begin
    if (nframes > 0 && ((($time - t_rise) / 10) < min_gap))
      min_gap = int'(($time - t_rise) / 10);
    if (nframes < 16) f_start[nframes] = nbytes;
    in_frame = 1;
  end
  always @(posedge spi_cs_no) if (in_frame) begin
    if (nframes < 16) f_len[nframes] = nbytes - f_start[nframes];
    if (bitcnt != 0) misalign++;
    nframes++;
    in_frame = 0;
    t_rise = $time;
  end

  // data source, poller and port monitors
  int feed_idx = 0;
  bit feed_stall = 0, tog = 0, feed_prog = 0;
  logic [7:0] feed_seed = 0;
  int p_delay = 3, p_cnt = 0;
  bit p_tmo = 0;
  logic [7:0] p_stat = 0;

  always @(posedge clk_i) if (data_valid_i && data_ready_o) feed_idx++;
  always @(negedge clk_i) begin
    tog = ~tog;
    data_valid_i = feed_prog && (!feed_stall || tog);
    data_i = feed_seed + 8'(feed_idx);
    if (spi_sclk_o && spi_cs_no) sclk_out++;
    if (data_ready_o && !feed_prog) ready_bad++;
    if (done_o) done_cnt++;
    poll_done_i = 0;
    poll_timeout_i = 0;
    if (p_cnt > 0) begin
      p_cnt--;
      if (p_cnt == 0) begin
        poll_status_i = p_stat;
        if (p_tmo) poll_timeout_i = 1; else poll_done_i = 1;
      end
    end
    if (poll_start_o) begin
      poll_cnt++;
      p_cnt = p_delay;
    end
  end

  logic [7:0] exp_b [0:511];
  int exp_fs [0:15];
  int exp_fl [0:15];

  task automatic run_op(input logic [62:0] v, input int poke);
    logic [1:0] op = v[62:61];
    logic lrst = v[60];
    int len = int'(v[59:52]);
    logic [23:0] row = v[51:28];
    logic [15:0] col = v[27:12];
    logic [1:0] eres = v[2:1];
    logic [1:0] got = 2'd3;
    int enf = 0, ne = 0, cyc = 0;
    string tag;
    tag = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R6" : "R10";
    // expected frames
    if (op[1]) begin
      exp_fs[0] = 0; exp_b[0] = 8'h04; exp_fl[0] = 1; enf = 1;
    end else begin
      exp_fs[0] = 0; exp_b[0] = 8'h06; exp_fl[0] = 1; ne = 1; enf = 1;
      if (op == 2'd0) begin
        exp_fs[1] = ne;
        exp_b[ne] = lrst ? 8'h02 : 8'h84;
        exp_b[ne+1] = col[15:8]; exp_b[ne+2] = col[7:0]; ne += 3;
        for (int k = 0; k < len; k++) begin exp_b[ne] = col[7:0] + 8'h3C + 8'(k); ne++; end
        exp_fl[1] = 3 + len; enf = 2;
      end
      exp_fs[enf] = ne;
      exp_b[ne] = (op == 2'd0) ? 8'h10 : 8'hD8;
      exp_b[ne+1] = row[23:16]; exp_b[ne+2] = row[15:8]; exp_b[ne+3] = row[7:0];
      exp_fl[enf] = 4; enf++;
    end
    @(negedge clk_i);
    nframes = 0; nbytes = 0; bitcnt = 0; misalign = 0; sclk_out = 0;
    min_gap = 1000; ready_bad = 0; done_cnt = 0; poll_cnt = 0;
    feed_idx = 0; feed_seed = col[7:0] + 8'h3C; feed_stall = v[0];
    feed_prog = (op == 2'd0); p_stat = v[11:4]; p_tmo = v[3];
    start_i = 1; op_i = op; load_rst_i = lrst; col_i = col; row_i = row;
    len_i = LEN_W'(len);
    @(negedge clk_i);
    start_i = 0;
    while (got == 2'd3 && cyc < 20000) begin
      @(negedge clk_i);
      cyc++;
      if (cyc == poke) begin start_i = 1; op_i = 2'd2; end
      else start_i = 0;
      if (done_o) got = result_o;
    end
    repeat (6) @(negedge clk_i);
    feed_prog = 0;
    chk(nframes == enf, tag, "frame count", nframes, enf);
    for (int f = 0; f < enf && f < nframes; f++) begin
      bit ok = (f_len[f] == exp_fl[f]);
      int bad = -1;
      for (int b = 0; b < exp_fl[f] && ok; b++)
        if (cap_b[f_start[f] + b] != exp_b[exp_fs[f] + b]) begin ok = 0; bad = b; end
      if (!ok && bad >= 0)
        chk(0, (op == 2'd0 && f == 1) ? "R4/R5" : tag, $sformatf("frame %0d byte %0d", f, bad),
            cap_b[f_start[f] + bad], exp_b[exp_fs[f] + bad]);
      else
        chk(ok, (len == 0 && op == 2'd0) ? "R12" : tag, $sformatf("frame %0d length", f),
            f_len[f], exp_fl[f]);
    end
    chk(got == eres, eres == 2'd2 ? "R9" : "R8", "result", got, eres);
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    chk(poll_cnt == (op[1] ? 0 : 1), "R7", "poll requests", poll_cnt, op[1] ? 0 : 1);
    chk(misalign == 0 && sclk_out == 0, "R2", "misaligned/unframed clocks",
        misalign + sclk_out, 0);
    if (enf > 1) chk(min_gap >= GAP, "R2", "cs gap", min_gap, GAP);
    chk(ready_bad == 0, "R5", "ready outside load", ready_bad, 0);
    if (op == 2'd0) chk(feed_idx == len, "R5", "bytes consumed", feed_idx, len);
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(spi_cs_no && !spi_sclk_o && !busy_o && !done_o && !poll_start_o && !data_ready_o,
        "R1", "outputs in reset", {spi_cs_no, spi_sclk_o, busy_o, done_o, poll_start_o}, 5'b10000);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    chk(spi_cs_no && !spi_sclk_o && !busy_o && !done_o && !poll_start_o && !data_ready_o,
        "R1", "outputs after reset", {spi_cs_no, spi_sclk_o, busy_o, done_o, poll_start_o}, 5'b10000);
    for (int i = 0; i < NV; i++) run_op(VECS[i], 0);
    // R11: a second start mid-job changes nothing
    run_op({2'd1, 1'b0, 8'd0, 24'h0A0B0C, 16'h0000, 8'h04, 1'b0, 2'd1, 1'b0}, 40);
    run_op({2'd0, 1'b1, 8'd2, 24'h000777, 16'h0020, 8'h00, 1'b0, 2'd0, 1'b1}, 90);
    // slow poller, program fail reported
    p_delay = 50;
    run_op({2'd0, 1'b0, 8'd1, 24'h00C0DE, 16'h07FF, 8'h0C, 1'b0, 2'd1, 1'b0}, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule